// File: doc/BRIEF.md
# Program Sequencer with Single-Entry Save Registers

This block produces the 11-bit program address for a small byte-coded I/O controller. It keeps the program counter and two single-entry save registers: one for subroutine linkage and one for interrupt linkage. It handles sequential advance, taken skips, jumps with an immediate target, jumps through the accumulator, calls and returns, and vectored interrupts. Instruction decode of arithmetic, the register file and the accumulator are handled by neighbouring logic. That logic hands this block the opcode byte, the second program byte, the accumulator, the three low bits of register zero and a skip verdict. It raises `step_i` for one clock when the current instruction finishes executing.

While an instruction executes, `pc_o` holds the address of that instruction's first byte. On the clock edge that ends the instruction, the counter moves to the next instruction. When the active-low request is low at that same edge, the new address is also copied into the interrupt save register. The following clock is a vector cycle: `intack_o` is high, the external device drives the vector onto the data bus, and the counter loads that byte with the page bits cleared.

Top module: `prog_seq`

## Requirements
- R1: After reset `pc_o` is 0, `intack_o` is 0, and both save registers hold 0.
- R2: A finished instruction that is not a control-flow opcode advances the PC by its length, modulo 2048. Opcodes 0x80–0x8F and 0xC0–0xDF are two bytes long, and all other opcodes are one byte long.
- R3: When `skip_i` is high on a finishing instruction that is not a control-flow opcode, the PC also steps over the next two program bytes (one-byte instruction: +3, modulo 2048). On control-flow opcodes `skip_i` has no effect.
- R4: Opcodes 0x80|p (plain jump) and 0x88|p (call) load the PC with {p, second byte}, where p is opcode bits 2:0.
- R5: Opcodes 0x90|z (jump through accumulator) and 0x98|z (call through accumulator) load the PC with {z OR r0_lo_i, acc_i}.
- R6: Both call forms (0x88–0x9F range, call variants) write the address of the call's first byte plus 2 into the subroutine save register.
- R7: Opcodes 0xB8 and 0xB9 load the PC from the subroutine save register and write the returning instruction's address plus 2 into that register.
- R8: If `irq_n_i` is low on the edge that ends an instruction, the interrupt save register receives the PC that the instruction computed. `intack_o` is then high for exactly the next clock, and at the end of that clock the PC becomes {3'b000, dbus_i}.
- R9: Opcodes 0xB0 and 0xB1 load the PC from the interrupt save register.
- R10: `step_i` has no effect during the vector cycle. Without `step_i`, the PC holds and `irq_n_i` is not acted on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Current instruction finishes on this edge |
| op_i | input | 8 | Opcode byte of the current instruction |
| imm_i | input | 8 | Second program byte of the current instruction |
| acc_i | input | 8 | Accumulator contents |
| r0_lo_i | input | 3 | Bits 2:0 of register zero |
| skip_i | input | 1 | Skip condition of the current instruction is met |
| irq_n_i | input | 1 | Interrupt request, active low |
| dbus_i | input | 8 | Data bus, carries the vector during the vector cycle |
| pc_o | output | 11 | Program counter |
| intack_o | output | 1 | Vector-cycle acknowledge |

## Verification
An interrupt can be taken on the same edge that a call, a return or a taken skip finishes. The bench raises the request together with a call. It then expects the interrupt save register to capture the call target and the subroutine save register to capture the return link. Both values are read back later through an interrupt return followed by a subroutine return. The bench also holds `step_i` high with a jump opcode during the vector cycle, and judges by the PC after that cycle that the vector load won and the jump was dropped.

// File: rtl/prog_seq.sv
module prog_seq #(
  parameter int PW = 3,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step_i,
  input  logic [7:0]      op_i,
  input  logic [DW-1:0]   imm_i,
  input  logic [DW-1:0]   acc_i,
  input  logic [PW-1:0]   r0_lo_i,
  input  logic            skip_i,
  input  logic            irq_n_i,
  input  logic [DW-1:0]   dbus_i,
  output logic [PW+DW-1:0] pc_o,
  output logic            intack_o
);
  localparam int AW = PW + DW;

  logic [AW-1:0] pc_q, ssr_q, isr_q, nxt_pc;
  logic          vec_q;

  wire fire   = step_i & ~vec_q;
  wire is_jmp = op_i[7:3] == 5'b10000;
  wire is_jsb = op_i[7:3] == 5'b10001;
  wire is_jai = op_i[7:3] == 5'b10010;
  wire is_jas = op_i[7:3] == 5'b10011;
  wire is_rti = op_i == 8'hB0 || op_i == 8'hB1;
  wire is_rts = op_i == 8'hB8 || op_i == 8'hB9;
  wire is_call = is_jsb | is_jas;
  wire flow   = is_jmp | is_jsb | is_jai | is_jas | is_rti | is_rts;
  wire two_b  = op_i[7:4] == 4'h8 || op_i[7:5] == 3'b110;

  wire [AW-1:0] link_pc = pc_q + AW'(2);
  wire [AW-1:0] seq_pc  = pc_q + AW'(two_b ? 2 : 1) + AW'((skip_i && !flow) ? 2 : 0);
  wire [AW-1:0] imm_tgt = {op_i[PW-1:0], imm_i};
  wire [AW-1:0] acc_tgt = {op_i[PW-1:0] | r0_lo_i, acc_i};

  always_comb begin
    nxt_pc = seq_pc;
    if (is_jmp || is_jsb)      nxt_pc = imm_tgt;
    else if (is_jai || is_jas) nxt_pc = acc_tgt;
    else if (is_rts)           nxt_pc = ssr_q;
    else if (is_rti)           nxt_pc = isr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      ssr_q <= '0;
      isr_q <= '0;
      vec_q <= 1'b0;
    end else if (vec_q) begin
      pc_q  <= {{PW{1'b0}}, dbus_i};
      vec_q <= 1'b0;
    end else if (fire) begin
      pc_q <= nxt_pc;
      if (is_call || is_rts) ssr_q <= link_pc;
      if (!irq_n_i) begin
        isr_q <= nxt_pc;
        vec_q <= 1'b1;
      end
    end
  end

  assign pc_o     = pc_q;
  assign intack_o = vec_q;

  // R8
  intack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intack_o |=> !intack_o);

  // R8
  vector_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intack_o |=> pc_o == {{PW{1'b0}}, $past(dbus_i)});

  // R8
  irq_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !intack_o && !irq_n_i) |=> (intack_o && isr_q == pc_o));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !intack_o) |=> ($stable(pc_o) && !intack_o));

  // R9
  irq_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !intack_o && is_rti) |=> pc_o == $past(isr_q));

  // R7
  sub_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !intack_o && is_rts) |=> (pc_o == $past(ssr_q) && ssr_q == $past(pc_o) + AW'(2)));
endmodule

// File: tb/test_prog_seq.sv
module test_prog_seq;
  logic clk = 0, rst_n = 0, step_i = 0, skip_i = 0, irq_n_i = 1;
  logic [7:0] op_i = 0, imm_i = 0, acc_i = 0, dbus_i = 0;
  logic [2:0] r0_lo_i = 0;
  logic [10:0] pc_o;
  logic intack_o;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  prog_seq i_prog_seq (.clk(clk), .rst_n(rst_n), .step_i(step_i), .op_i(op_i), .imm_i(imm_i),
    .acc_i(acc_i), .r0_lo_i(r0_lo_i), .skip_i(skip_i), .irq_n_i(irq_n_i), .dbus_i(dbus_i),
    .pc_o(pc_o), .intack_o(intack_o));

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic exec(input logic [7:0] op, input logic [7:0] imm, input logic skp,
                      input logic [2:0] r0, input logic [7:0] acc);
    @(negedge clk);
    op_i = op; imm_i = imm; skip_i = skp; r0_lo_i = r0; acc_i = acc; step_i = 1;
    @(negedge clk);
    step_i = 0; skip_i = 0;
  endtask

  task automatic t_reset;
    chk("R1 pc", pc_o, 0);
    chk("R1 intack", intack_o, 0);
  endtask

  task automatic t_sequential;
    exec(8'h00, 0, 0, 0, 0); chk("R2 one-byte", pc_o, 11'h001);
    exec(8'hCF, 8'h12, 0, 0, 0); chk("R2 two-byte CF", pc_o, 11'h003);
    exec(8'hD5, 8'h12, 0, 0, 0); chk("R2 two-byte D5", pc_o, 11'h005);
    exec(8'h3C, 0, 0, 0, 0); chk("R2 one-byte 3C", pc_o, 11'h006);
  endtask

  task automatic t_skip_jump;
    exec(8'h85, 8'h40, 0, 0, 0); chk("R4 jmp", pc_o, 11'h540);
    exec(8'h00, 0, 1, 0, 0); chk("R3 skip", pc_o, 11'h543);
    exec(8'h80, 8'hFE, 1, 0, 0); chk("R3 skip ignored on jmp", pc_o, 11'h0FE);
    exec(8'h87, 8'hFE, 0, 0, 0); chk("R4 jmp top", pc_o, 11'h7FE);
    exec(8'h00, 0, 1, 0, 0); chk("R3 skip wraps", pc_o, 11'h001);
    exec(8'h87, 8'hFF, 0, 0, 0);
    exec(8'h00, 0, 0, 0, 0); chk("R2 wrap", pc_o, 11'h000);
  endtask

  task automatic t_subroutine;
    exec(8'h81, 8'h20, 0, 0, 0);
    exec(8'h8A, 8'h33, 0, 0, 0); chk("R4 jsb target", pc_o, 11'h233);
    exec(8'hB8, 0, 1, 0, 0); chk("R6 jsb link", pc_o, 11'h122);
    exec(8'hB9, 0, 0, 0, 0); chk("R7 swap link", pc_o, 11'h235);
    exec(8'h83, 8'h00, 0, 0, 0);
    exec(8'h99, 0, 0, 3'b110, 8'h77); chk("R5 jas target", pc_o, 11'h777);
    exec(8'hB8, 0, 0, 0, 0); chk("R6 jas link", pc_o, 11'h302);
    exec(8'h94, 0, 0, 3'b001, 8'h10); chk("R5 jai target", pc_o, 11'h510);
  endtask

  task automatic irq_take(input logic [7:0] op, input logic [7:0] imm, input logic [10:0] exp_nxt,
                          input logic [7:0] vec, input string tag);
    @(negedge clk);
    op_i = op; imm_i = imm; step_i = 1; irq_n_i = 0;
    @(negedge clk);
    irq_n_i = 1; dbus_i = vec;
    op_i = 8'h86; imm_i = 8'h55;
    chk({"R8 intack ", tag}, intack_o, 1);
    chk({"R8 next pc ", tag}, pc_o, exp_nxt);
    @(negedge clk);
    step_i = 0; dbus_i = 0;
    chk({"R8 intack one clock ", tag}, intack_o, 0);
    chk({"R8/R10 vector ", tag}, pc_o, {3'b000, vec});
  endtask

  task automatic t_interrupt;
    irq_take(8'h00, 0, 11'h511, 8'hA5, "plain");
    exec(8'hB0, 0, 0, 0, 0); chk("R9 rti", pc_o, 11'h511);
    irq_take(8'h8C, 8'h10, 11'h410, 8'h3C, "on call");
    exec(8'hB1, 0, 0, 0, 0); chk("R9 rte to call target", pc_o, 11'h410);
    exec(8'hB8, 0, 0, 0, 0); chk("R6 link kept under irq", pc_o, 11'h513);
  endtask

  task automatic t_idle;
    @(negedge clk);
    irq_n_i = 0; op_i = 8'h85;
    repeat (4) @(negedge clk);
    chk("R10 pc holds", pc_o, 11'h513);
    chk("R10 no intack", intack_o, 0);
    irq_n_i = 1;
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_sequential();
    t_skip_jump();
    t_subroutine();
    t_interrupt();
    t_idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule